// File: doc/BRIEF.md
# LIN Wake Detector

This block watches a digitized LIN bus level and a digitized wake input, and reports the two kinds of wake-up a LIN node must recognise while it is powered down or idle. A change of level on the wake input, once it has stayed put for a debounce time, gives a local wake. The mode controller acts on a local wake only in sleep. A remote wake needs a complete bus pattern: a recessive-to-dominant edge, a dominant phase that lasts longer than a programmable minimum, then a return to recessive. It is recognised in both sleep and standby.

Each wake is reported as a single-cycle pulse. A remote wake also sets a sticky flag. The mode controller uses this flag to hold the receive output low, so that the host can see the wake came from the bus. The controller clears the flag with `flag_clear` when it enters a normal mode. Both time limits are counted in a microsecond tick that comes from outside the block. Both asynchronous inputs pass through two-flop synchronizers before any logic uses them. Analog thresholds and bus glitch filtering belong to other blocks.

Top module: `lin_wake_detect`

## Requirements
- R1: The mode encoding is 0 = sleep, 1 = standby, 2 = normal, 3 = normal with low slope. After reset, `local_wake`, `remote_wake` and `remote_flag` are low, and the accepted wake-input level is low.
- R2: In sleep, with `tick` high every cycle, a wake input that rises and stays high for DEB_TICKS cycles or more gives exactly one `local_wake` pulse.
- R3: A falling level on the wake input, held for DEB_TICKS cycles or more in sleep, also gives one `local_wake` pulse.
- R4: A wake-input excursion shorter than DEB_TICKS cycles (tick every cycle) gives no `local_wake`.
- R5: Outside sleep, no `local_wake` is produced, but the accepted level still follows the input. Entering sleep with the level already changed gives no wake.
- R6: In sleep or standby, with tick every cycle, a dominant phase of WAKE_TICKS+1 cycles or more followed by recessive gives exactly one `remote_wake` pulse.
- R7: A dominant phase of WAKE_TICKS cycles or fewer gives no `remote_wake`.
- R8: `remote_wake` occurs only on the return to recessive. A dominant level that is held long and not yet released gives no pulse.
- R9: The bus is monitored only in sleep and standby. Dominant phases in modes 2 and 3 give nothing. A qualified dominant phase interrupted by leaving standby gives no wake when the bus is later released.
- R10: If the bus is already dominant when monitoring starts, it must go recessive before a new pattern can begin. A pattern that follows that recessive phase is recognised.
- R11: `remote_flag` rises the cycle after `remote_wake`, stays set, and clears the cycle after `flag_clear` when no new remote wake arrives at the same time.
- R12: Both time windows count only cycles in which `tick` is high. With `tick` low the windows do not advance.
- R13: Each wake output is high for one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time-base strobe (nominally 1 us) |
| bus_dominant | input | 1 | Digitized bus level, 1 = dominant (asynchronous) |
| wake_pin | input | 1 | Digitized wake input level (asynchronous) |
| mode | input | 2 | Operating mode from the controller (encoding in R1) |
| flag_clear | input | 1 | Clears the sticky remote-wake flag |
| local_wake | output | 1 | One-cycle local wake pulse |
| remote_wake | output | 1 | One-cycle remote wake pulse |
| remote_flag | output | 1 | Sticky remote-wake flag |

## Verification
The bench sweeps the pulse length through and past both windows. An off-by-one count would move the threshold cycle, and a missing either-polarity path would report only half the local wakes. It checks a long dominant phase that has not been released, monitoring that stops mid-pattern, and a bus that is already dominant when standby is entered. A detector that fires on duration alone, or that keeps its progress while disabled, gives spurious remote wakes in these cases. It also runs the tick at half rate and at zero, to show that the windows count time and not clock cycles.

// File: rtl/lwd_pkg.sv
package lwd_pkg;
  typedef enum logic [1:0] {
    MD_SLEEP = 2'd0,
    MD_STBY  = 2'd1,
    MD_NORM  = 2'd2,
    MD_SLOW  = 2'd3
  } lwd_mode_e;

  typedef enum logic [1:0] {
    RW_BLOCK,
    RW_IDLE,
    RW_DOM,
    RW_LONG
  } rw_state_e;

  // bus pattern is watched in sleep and standby only
  function automatic logic lwd_listen(input logic [1:0] m);
    return (m == MD_SLEEP) || (m == MD_STBY);
  endfunction

  function automatic logic lwd_asleep(input logic [1:0] m);
    return m == MD_SLEEP;
  endfunction
endpackage

// File: rtl/lwd_sync.sv
module lwd_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/lwd_debounce.sv
module lwd_debounce #(
  parameter int DEB_TICKS = 20,
  parameter int CW        = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_s,
  input  logic asleep,
  output logic wake_pulse,
  output logic deb_hit
);
  logic          level;
  logic [CW-1:0] cnt;
  logic          differs;

  assign differs = pin_s != level;
  assign deb_hit = differs && tick && (cnt == CW'(DEB_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level      <= 1'b0;
      cnt        <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      if (!differs) begin
        cnt <= '0;
      end else if (deb_hit) begin
        level      <= pin_s;
        cnt        <= '0;
        wake_pulse <= asleep;
      end else if (tick) begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/lwd_remote.sv
module lwd_remote
  import lwd_pkg::*;
#(
  parameter int WAKE_TICKS = 60,
  parameter int CW         = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dom_s,
  input  logic listen,
  output logic wake_pulse,
  output logic armed
);
  rw_state_e     st;
  logic [CW-1:0] cnt;

  assign armed = st == RW_LONG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RW_BLOCK;
      cnt        <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      if (!listen) begin
        st <= RW_BLOCK;
      end else begin
        case (st)
          RW_BLOCK: if (!dom_s) st <= RW_IDLE;
          RW_IDLE: if (dom_s) begin
            st  <= RW_DOM;
            cnt <= '0;
          end
          RW_DOM: begin
            if (!dom_s) st <= RW_IDLE;
            else if (tick) begin
              if (cnt == CW'(WAKE_TICKS - 1)) st <= RW_LONG;
              else cnt <= cnt + CW'(1);
            end
          end
          RW_LONG: if (!dom_s) begin
            st         <= RW_IDLE;
            wake_pulse <= 1'b1;
          end
          default: st <= RW_BLOCK;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect
  import lwd_pkg::*;
#(
  parameter int DEB_TICKS  = 20,
  parameter int WAKE_TICKS = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_dominant,
  input  logic       wake_pin,
  input  logic [1:0] mode,
  input  logic       flag_clear,
  output logic       local_wake,
  output logic       remote_wake,
  output logic       remote_flag
);
  localparam int DEB_W  = $clog2(DEB_TICKS + 1);
  localparam int WAKE_W = $clog2(WAKE_TICKS + 1);

  logic [1:0] raw_in, syn_in;
  logic       bus_s, pin_s, armed, deb_hit;

  assign raw_in = {bus_dominant, wake_pin};
  assign bus_s  = syn_in[1];
  assign pin_s  = syn_in[0];

  lwd_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  lwd_debounce #(.DEB_TICKS(DEB_TICKS), .CW(DEB_W)) u_local (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_s(pin_s),
    .asleep(lwd_asleep(mode)), .wake_pulse(local_wake), .deb_hit(deb_hit)
  );

  lwd_remote #(.WAKE_TICKS(WAKE_TICKS), .CW(WAKE_W)) u_remote (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dom_s(bus_s),
    .listen(lwd_listen(mode)), .wake_pulse(remote_wake), .armed(armed)
  );

  // a fresh wake wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remote_flag <= 1'b0;
    else if (remote_wake) remote_flag <= 1'b1;
    else if (flag_clear) remote_flag <= 1'b0;
  end
endmodule

// File: rtl/lwd_checker.sv
module lwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       local_wake,
  input logic       remote_wake,
  input logic       remote_flag,
  input logic       flag_clear,
  input logic       armed,
  input logic       bus_s
);
  // R5
  local_only_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_wake |-> ($past(mode) == 2'd0));
  // R9
  remote_only_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wake |-> !$past(mode[1]));
  // R8
  remote_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wake |-> ($past(armed) && !$past(bus_s)));
  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wake |=> remote_flag);
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clear && !remote_wake) |=> !remote_flag);
  // R13
  remote_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remote_wake |=> !remote_wake);
endmodule

bind lin_wake_detect lwd_checker u_lwd_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .local_wake(local_wake),
  .remote_wake(remote_wake), .remote_flag(remote_flag),
  .flag_clear(flag_clear), .armed(armed), .bus_s(bus_s)
);

// File: tb/tb_lin_wake_detect.sv
module tb_lin_wake_detect;
  localparam int DEB  = 4;
  localparam int WK   = 6;
  localparam logic [1:0] SLEEP = 2'd0, STBY = 2'd1, NORM = 2'd2, LOWS = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic bus = 1'b0, pin = 1'b0, clr = 1'b0;
  logic [1:0] mode = SLEEP;
  logic lw, rw, rf;
  logic tick_en = 1'b1, tick_alt = 1'b0;
  int checks = 0, fails = 0;
  int lw_n = 0, rw_n = 0, multi = 0;
  logic lw_q = 1'b0, rw_q = 1'b0;

  always #2 clk = ~clk;

  lin_wake_detect #(.DEB_TICKS(DEB), .WAKE_TICKS(WK)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_dominant(bus),
    .wake_pin(pin), .mode(mode), .flag_clear(clr),
    .local_wake(lw), .remote_wake(rw), .remote_flag(rf)
  );

  always @(negedge clk) tick <= tick_alt ? ~tick : tick_en;

  always @(posedge clk) begin
    #1;
    if (lw) lw_n++;
    if (rw) rw_n++;
    if ((lw && lw_q) || (rw && rw_q)) multi++;
    lw_q = lw;
    rw_q = rw;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic zero();
    lw_n = 0;
    rw_n = 0;
  endtask

  task automatic drop_flag();
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(3);
    // R1 reset state
    chk("R1 local_wake", int'(lw), 0);
    chk("R1 remote_wake", int'(rw), 0);
    chk("R1 remote_flag", int'(rf), 0);
    chk("R1 no events", lw_n + rw_n, 0);

    // R2 R4: sweep of excursion length in sleep
    for (int n = 1; n <= DEB + 2; n++) begin
      zero();
      pin = 1'b1;
      step(n);
      pin = 1'b0;
      step(2 * DEB + 6);
      chk(n >= DEB ? "R2 rise+fall count" : "R4 short excursion", lw_n, n >= DEB ? 2 : 0);
    end

    // R2 then R3 separately
    zero();
    pin = 1'b1;
    step(DEB + 4);
    chk("R2 rising edge", lw_n, 1);
    pin = 1'b0;
    step(DEB + 4);
    chk("R3 falling edge", lw_n, 2);

    // R5: change outside sleep tracked, not reported
    for (int m = 1; m <= 3; m++) begin
      zero();
      mode = 2'(m);
      pin = ~pin;
      step(DEB + 6);
      chk("R5 no wake outside sleep", lw_n, 0);
      mode = SLEEP;
      step(DEB + 6);
      chk("R5 level tracked", lw_n, 0);
    end
    zero();
    pin = ~pin;
    step(DEB + 6);
    chk("R5 sleep after tracking", lw_n, 1);
    if (pin) begin
      pin = 1'b0;
      step(DEB + 6);
    end

    // R12 local: no tick, no progress
    zero();
    tick_en = 1'b0;
    pin = 1'b1;
    step(3 * DEB);
    chk("R12 local frozen", lw_n, 0);
    tick_en = 1'b1;
    step(DEB + 4);
    chk("R12 local resumes", lw_n, 1);
    pin = 1'b0;
    step(DEB + 6);

    // R6 R7 R11: remote sweep in sleep and standby
    for (int m = 0; m <= 1; m++) begin
      mode = 2'(m);
      step(3);
      for (int n = 1; n <= WK + 3; n++) begin
        zero();
        bus = 1'b1;
        step(n);
        bus = 1'b0;
        step(6);
        chk(n > WK ? "R6 remote count" : "R7 short dominant", rw_n, n > WK ? 1 : 0);
        chk("R11 flag after pattern", int'(rf), n > WK ? 1 : 0);
        drop_flag();
        chk("R11 flag cleared", int'(rf), 0);
      end
    end
    chk("R5 no local during remote sweep", lw_n, 0);

    // R8: long dominant, not released
    mode = STBY;
    zero();
    bus = 1'b1;
    step(4 * WK);
    chk("R8 held dominant", rw_n, 0);
    chk("R8 flag still low", int'(rf), 0);
    bus = 1'b0;
    step(6);
    chk("R8 release wakes", rw_n, 1);
    step(10);
    chk("R11 flag sticky", int'(rf), 1);
    drop_flag();

    // R9: normal modes ignore the bus
    for (int m = 2; m <= 3; m++) begin
      zero();
      mode = 2'(m);
      bus = 1'b1;
      step(2 * WK);
      bus = 1'b0;
      step(6);
      chk("R9 normal mode ignored", rw_n, 0);
      chk("R9 flag untouched", int'(rf), 0);
    end
    // R9: leave standby while armed
    zero();
    mode = STBY;
    step(3);
    bus = 1'b1;
    step(WK + 4);
    mode = NORM;
    step(2);
    bus = 1'b0;
    step(6);
    mode = STBY;
    step(6);
    chk("R9 interrupted pattern", rw_n, 0);

    // R10: bus dominant when monitoring starts
    zero();
    mode = LOWS;
    bus = 1'b1;
    step(3);
    mode = STBY;
    step(2 * WK);
    bus = 1'b0;
    step(6);
    chk("R10 no edge seen", rw_n, 0);
    bus = 1'b1;
    step(WK + 3);
    bus = 1'b0;
    step(6);
    chk("R10 later pattern", rw_n, 1);
    drop_flag();

    // R12 remote: half-rate tick
    tick_alt = 1'b1;
    zero();
    bus = 1'b1;
    step(WK + 2);
    bus = 1'b0;
    step(6);
    chk("R12 half rate short", rw_n, 0);
    bus = 1'b1;
    step(3 * WK);
    bus = 1'b0;
    step(6);
    chk("R12 half rate long", rw_n, 1);
    tick_alt = 1'b0;
    step(2);

    // R13
    chk("R13 single-cycle pulses", multi, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule